// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Picker

This block chooses which pending DRAM burst a memory controller should issue next. It looks at a small queue of bursts, each tagged with rank, bank, row and direction. It compares them against the state of every bank: whether a row is open, which row that is, and when the next read, write or activate may be issued. It also takes one availability flag per rank. The choice is combinational. The result (queue index, column-command time, a found flag and the priority tier that won) is captured into output registers on a one-cycle strobe.

Bursts that hit an open row are preferred. A hit that can take its column command no later than the supplied minimum column time ranks above everything else. Otherwise the oldest ready hit is used, unless a row miss targets a bank that can be opened early enough to hide its activate. Such a miss wins over that hit. Misses are only ever aimed at the banks that can be activated soonest. Those banks are found in one pass over the banks that have eligible work waiting.

Timing values such as the activate-to-column delay, the current time and the per-bank allowed times are inputs. Refresh and power state appear only through the per-rank availability flag.

Top module: `row_hit_picker`

## Requirements
- R1: While reset is high and in the cycle after it, res_valid, res_found, res_idx, res_col and res_kind are all zero.
- R2: res_valid is high in exactly the cycle after pick_go is high. res_found, res_idx, res_col and res_kind change only on a clock edge where pick_go is high.
- R3: An entry takes part only if its valid bit is set and its rank's rank_ready bit is set. An invalid entry, or one in an unavailable rank, is never picked and adds nothing to the bank mask.
- R4: A hit is an eligible entry whose bank is open with a stored row equal to the entry's row. A hit whose column time is at or below min_col is seamless. When any seamless hit exists, the lowest-index one is picked with res_kind = 1.
- R5: With no seamless hit and no hidden miss, the lowest-index hit is picked with res_kind = 3, ahead of any miss.
- R6: The bank mask holds only banks with eligible waiting entries. Walking banks in ascending id, a bank joins if its column time is at or below min_col, or if no such bank has joined yet and its activate time is at or below the smallest seen so far. The mask is cleared first when the new bank is strictly better. A miss picks the lowest-index non-hit entry whose bank is in the mask, with res_kind = 4.
- R7: The hidden flag takes the value of the last bank added to the mask: its activate time at or below max(min_col - rcd saturated at 0, now). When the flag is set and a masked miss exists, the miss is picked with res_kind = 2, even over a non-seamless hit.
- R8: res_col is the chosen entry's bank read-allowed time for a read entry (q_is_read = 1), or its write-allowed time for a write entry.
- R9: When no entry qualifies, res_found = 0 and res_idx, res_col and res_kind are all 0.
- R10: For the mask, a bank's activate time is max(activate-allowed time, now). Its column time is max(direction time, activate time + rcd). The direction time is the read-allowed time if any eligible read waits on the bank, otherwise the write-allowed time.
- R11: An entry's bank id is rank * BANKS_PER_RANK + bank. Per-entry field i sits at bits [i*W +: W] of its flat port, and per-bank field b at [b*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pick_go | input | 1 | Strobe: capture the current pick |
| now | input | TIME_W | Current time |
| min_col | input | TIME_W | Earliest column time the data bus can accept |
| rcd | input | TIME_W | Activate-to-column delay |
| q_valid | input | DEPTH | Entry valid bits |
| q_rank | input | DEPTH*RANK_W | Entry rank fields |
| q_bank | input | DEPTH*BANK_W | Entry bank-in-rank fields |
| q_row | input | DEPTH*ROW_W | Entry row fields |
| q_is_read | input | DEPTH | 1 = read entry, 0 = write entry |
| rank_ready | input | RANKS | Rank may accept commands |
| bank_open | input | NB | Bank has an open row |
| bank_row | input | NB*ROW_W | Open row per bank |
| bank_rd_at | input | NB*TIME_W | Read column allowed time per bank |
| bank_wr_at | input | NB*TIME_W | Write column allowed time per bank |
| bank_act_at | input | NB*TIME_W | Activate allowed time per bank |
| res_valid | output | 1 | Result captured last cycle |
| res_found | output | 1 | An entry was chosen |
| res_idx | output | IDX_W | Chosen queue index |
| res_col | output | TIME_W | Column time of chosen entry |
| res_kind | output | 3 | 0 none, 1 seamless hit, 2 hidden miss, 3 ready hit, 4 miss |

## Verification
The assertions assume that every rank field is below RANKS and every bank field below BANKS_PER_RANK, so each bank id addresses a real bank. They also assume that the timing inputs are steady during the cycle pick_go is sampled. The stimulus builds every entry from fields drawn inside those ranges. It changes inputs only on the falling edge, before the strobe is raised, so each captured pick sees a settled queue and bank state.

// File: rtl/pick_pkg.sv
package pick_pkg;
  typedef enum logic [2:0] {
    PK_NONE   = 3'd0,
    PK_SEAM   = 3'd1,
    PK_HIDDEN = 3'd2,
    PK_PREP   = 3'd3,
    PK_MISS   = 3'd4
  } pick_kind_e;
endpackage

// File: rtl/pick_first.sv
// Lowest-index set bit finder.
module pick_first #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pick_entry_class.sv
// Per-entry classification: eligibility, row hit, column time, seamless.
module pick_entry_class #(
  parameter int DEPTH  = 16,
  parameter int RANKS  = 2,
  parameter int BPR    = 4,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 16,
  localparam int NB     = RANKS * BPR,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BPR > 1) ? $clog2(BPR) : 1,
  localparam int BID_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [DEPTH-1:0]        q_valid,
  input  logic [DEPTH*RANK_W-1:0] q_rank,
  input  logic [DEPTH*BANK_W-1:0] q_bank,
  input  logic [DEPTH*ROW_W-1:0]  q_row,
  input  logic [DEPTH-1:0]        q_is_read,
  input  logic [RANKS-1:0]        rank_ready,
  input  logic [NB-1:0]           bank_open,
  input  logic [NB*ROW_W-1:0]     bank_row,
  input  logic [NB*TIME_W-1:0]    bank_rd_at,
  input  logic [NB*TIME_W-1:0]    bank_wr_at,
  input  logic [TIME_W-1:0]       min_col,
  output logic [DEPTH-1:0]        elig,
  output logic [DEPTH-1:0]        hit,
  output logic [DEPTH-1:0]        seam,
  output logic [DEPTH*TIME_W-1:0] ent_col,
  output logic [DEPTH*BID_W-1:0]  ent_bid,
  output logic [NB-1:0]           waiting,
  output logic [NB-1:0]           waiting_rd
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [RANK_W-1:0] rk;
    logic [BID_W-1:0]  bid;
    logic [TIME_W-1:0] col;
    assign rk  = q_rank[i*RANK_W +: RANK_W];
    assign bid = BID_W'(rk) * BID_W'(BPR) + BID_W'(q_bank[i*BANK_W +: BANK_W]);
    assign col = q_is_read[i] ? bank_rd_at[bid*TIME_W +: TIME_W]
                              : bank_wr_at[bid*TIME_W +: TIME_W];
    assign elig[i] = q_valid[i] & rank_ready[rk];
    assign hit[i]  = elig[i] & bank_open[bid] &
                     (bank_row[bid*ROW_W +: ROW_W] == q_row[i*ROW_W +: ROW_W]);
    assign seam[i] = hit[i] & (col <= min_col);
    assign ent_col[i*TIME_W +: TIME_W] = col;
    assign ent_bid[i*BID_W +: BID_W]   = bid;
  end

  always_comb begin
    waiting    = '0;
    waiting_rd = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i]) begin
        waiting[ent_bid[i*BID_W +: BID_W]] = 1'b1;
        if (q_is_read[i]) waiting_rd[ent_bid[i*BID_W +: BID_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pick_bank_mask.sv
// Earliest-activatable bank mask and hidden-prepare flag.
module pick_bank_mask #(
  parameter int NB     = 8,
  parameter int TIME_W = 16,
  localparam int TW1   = TIME_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NB-1:0]        waiting,
  input  logic [NB-1:0]        waiting_rd,
  input  logic [NB*TIME_W-1:0] bank_act_at,
  input  logic [NB*TIME_W-1:0] bank_rd_at,
  input  logic [NB*TIME_W-1:0] bank_wr_at,
  input  logic [TIME_W-1:0]    now,
  input  logic [TIME_W-1:0]    min_col,
  input  logic [TIME_W-1:0]    rcd,
  output logic [NB-1:0]        mask,
  output logic                 hidden
);
  always_comb begin
    logic [TW1-1:0] min_act;
    logic [TW1-1:0] act_v;
    logic [TW1-1:0] col_v;
    logic [TW1-1:0] dir_v;
    logic [TW1-1:0] hmax;
    logic           seam_f;
    logic           new_seam;
    mask    = '0;
    hidden  = 1'b0;
    seam_f  = 1'b0;
    min_act = '1;
    hmax    = (min_col > rcd) ? {1'b0, min_col - rcd} : '0;
    if (hmax < {1'b0, now}) hmax = {1'b0, now};
    for (int b = 0; b < NB; b++) begin
      act_v = {1'b0, bank_act_at[b*TIME_W +: TIME_W]};
      if (act_v < {1'b0, now}) act_v = {1'b0, now};
      dir_v = waiting_rd[b] ? {1'b0, bank_rd_at[b*TIME_W +: TIME_W]}
                            : {1'b0, bank_wr_at[b*TIME_W +: TIME_W]};
      col_v = act_v + {1'b0, rcd};
      if (col_v < dir_v) col_v = dir_v;
      new_seam = col_v <= {1'b0, min_col};
      if (waiting[b] && (new_seam || (!seam_f && act_v <= min_act))) begin
        if (!seam_f && (new_seam || act_v < min_act)) mask = '0;
        seam_f  = seam_f | new_seam;
        mask[b] = 1'b1;
        hidden  = act_v <= hmax;
        min_act = act_v;
      end
    end
  end

  // R6
  mask_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (mask & ~waiting) == '0);

  // R6
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (|waiting) |-> (|mask));
endmodule

// File: rtl/row_hit_picker.sv
module row_hit_picker #(
  parameter int DEPTH  = 16,
  parameter int RANKS  = 2,
  parameter int BPR    = 4,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 16,
  localparam int NB     = RANKS * BPR,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BPR > 1) ? $clog2(BPR) : 1,
  localparam int BID_W  = (NB > 1) ? $clog2(NB) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pick_go,
  input  logic [TIME_W-1:0]       now,
  input  logic [TIME_W-1:0]       min_col,
  input  logic [TIME_W-1:0]       rcd,
  input  logic [DEPTH-1:0]        q_valid,
  input  logic [DEPTH*RANK_W-1:0] q_rank,
  input  logic [DEPTH*BANK_W-1:0] q_bank,
  input  logic [DEPTH*ROW_W-1:0]  q_row,
  input  logic [DEPTH-1:0]        q_is_read,
  input  logic [RANKS-1:0]        rank_ready,
  input  logic [NB-1:0]           bank_open,
  input  logic [NB*ROW_W-1:0]     bank_row,
  input  logic [NB*TIME_W-1:0]    bank_rd_at,
  input  logic [NB*TIME_W-1:0]    bank_wr_at,
  input  logic [NB*TIME_W-1:0]    bank_act_at,
  output logic                    res_valid,
  output logic                    res_found,
  output logic [IDX_W-1:0]        res_idx,
  output logic [TIME_W-1:0]       res_col,
  output logic [2:0]              res_kind
);
  import pick_pkg::*;

  logic [DEPTH-1:0]        elig, hit, seam, miss_req;
  logic [DEPTH*TIME_W-1:0] ent_col;
  logic [DEPTH*BID_W-1:0]  ent_bid;
  logic [NB-1:0]           waiting, waiting_rd, mask;
  logic                    hidden;
  logic                    seam_any, hit_any, miss_any;
  logic [IDX_W-1:0]        seam_idx, hit_idx, miss_idx, sel_idx;
  logic [TIME_W-1:0]       sel_col;
  pick_kind_e              sel_kind, kind_q;

  pick_entry_class #(.DEPTH(DEPTH), .RANKS(RANKS), .BPR(BPR),
                     .ROW_W(ROW_W), .TIME_W(TIME_W)) u_class (
    .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
    .q_is_read(q_is_read), .rank_ready(rank_ready), .bank_open(bank_open),
    .bank_row(bank_row), .bank_rd_at(bank_rd_at), .bank_wr_at(bank_wr_at),
    .min_col(min_col), .elig(elig), .hit(hit), .seam(seam),
    .ent_col(ent_col), .ent_bid(ent_bid), .waiting(waiting),
    .waiting_rd(waiting_rd)
  );

  pick_bank_mask #(.NB(NB), .TIME_W(TIME_W)) u_mask (
    .clk(clk), .rst(rst), .waiting(waiting), .waiting_rd(waiting_rd),
    .bank_act_at(bank_act_at), .bank_rd_at(bank_rd_at),
    .bank_wr_at(bank_wr_at), .now(now), .min_col(min_col), .rcd(rcd),
    .mask(mask), .hidden(hidden)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_miss
    assign miss_req[i] = elig[i] & ~hit[i] & mask[ent_bid[i*BID_W +: BID_W]];
  end

  pick_first #(.N(DEPTH), .IW(IDX_W)) u_seam_first (
    .req(seam), .any(seam_any), .idx(seam_idx));
  pick_first #(.N(DEPTH), .IW(IDX_W)) u_hit_first (
    .req(hit), .any(hit_any), .idx(hit_idx));
  pick_first #(.N(DEPTH), .IW(IDX_W)) u_miss_first (
    .req(miss_req), .any(miss_any), .idx(miss_idx));

  always_comb begin
    sel_kind = PK_NONE;
    sel_idx  = '0;
    if (seam_any) begin
      sel_kind = PK_SEAM;
      sel_idx  = seam_idx;
    end else if (miss_any && hidden) begin
      sel_kind = PK_HIDDEN;
      sel_idx  = miss_idx;
    end else if (hit_any) begin
      sel_kind = PK_PREP;
      sel_idx  = hit_idx;
    end else if (miss_any) begin
      sel_kind = PK_MISS;
      sel_idx  = miss_idx;
    end
    sel_col = (sel_kind == PK_NONE) ? '0 : ent_col[sel_idx*TIME_W +: TIME_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_idx   <= '0;
      res_col   <= '0;
      kind_q    <= PK_NONE;
    end else begin
      res_valid <= pick_go;
      if (pick_go) begin
        res_found <= (sel_kind != PK_NONE);
        res_idx   <= sel_idx;
        res_col   <= sel_col;
        kind_q    <= sel_kind;
      end
    end
  end

  assign res_kind = kind_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pick_go |=> res_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pick_go |=> !res_valid);

  // R3
  pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_go && sel_kind != PK_NONE) |->
      (q_valid[sel_idx] && rank_ready[q_rank[sel_idx*RANK_W +: RANK_W]]));

  // R4
  seam_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_go && (|seam)) |-> (sel_kind == PK_SEAM && seam[sel_idx]));

  // R7
  hidden_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_go && !(|seam) && hidden && (|miss_req)) |-> !hit[sel_idx]);

  // R9
  none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_found) |-> (res_col == '0 && res_idx == '0 && res_kind == 3'd0));
endmodule

// File: tb/tb_row_hit_picker.sv
`timescale 1ns/1ps
module tb_row_hit_picker;
  localparam int D = 16, RK = 2, BP = 4, NB = 8, RW = 8, TW = 16, IW = 4;

  logic clk = 1'b0, rst = 1'b1, pick_go = 1'b0;
  always #10 clk = ~clk;

  logic          e_v[D], e_rk[D], e_rd[D];
  logic [1:0]    e_bk[D];
  logic [RW-1:0] e_row[D];
  logic          rk_ok[RK];
  logic          b_open[NB];
  logic [RW-1:0] b_row[NB];
  logic [TW-1:0] b_rd[NB], b_wr[NB], b_act[NB];
  logic [TW-1:0] now_t, minc_t, rcd_t;

  logic [D-1:0]     q_valid, q_rank, q_is_read;
  logic [D*2-1:0]   q_bank;
  logic [D*RW-1:0]  q_row;
  logic [RK-1:0]    rank_ready;
  logic [NB-1:0]    bank_open;
  logic [NB*RW-1:0] bank_row;
  logic [NB*TW-1:0] bank_rd_at, bank_wr_at, bank_act_at;
  logic             res_valid, res_found;
  logic [IW-1:0]    res_idx;
  logic [TW-1:0]    res_col;
  logic [2:0]       res_kind;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      q_valid[i] = e_v[i]; q_rank[i] = e_rk[i]; q_is_read[i] = e_rd[i];
      q_bank[i*2 +: 2] = e_bk[i]; q_row[i*RW +: RW] = e_row[i];
    end
    for (int r = 0; r < RK; r++) rank_ready[r] = rk_ok[r];
    for (int b = 0; b < NB; b++) begin
      bank_open[b] = b_open[b]; bank_row[b*RW +: RW] = b_row[b];
      bank_rd_at[b*TW +: TW] = b_rd[b]; bank_wr_at[b*TW +: TW] = b_wr[b];
      bank_act_at[b*TW +: TW] = b_act[b];
    end
  end

  row_hit_picker #(.DEPTH(D), .RANKS(RK), .BPR(BP), .ROW_W(RW), .TIME_W(TW)) dut (
    .clk(clk), .rst(rst), .pick_go(pick_go), .now(now_t), .min_col(minc_t),
    .rcd(rcd_t), .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank),
    .q_row(q_row), .q_is_read(q_is_read), .rank_ready(rank_ready),
    .bank_open(bank_open), .bank_row(bank_row), .bank_rd_at(bank_rd_at),
    .bank_wr_at(bank_wr_at), .bank_act_at(bank_act_at), .res_valid(res_valid),
    .res_found(res_found), .res_idx(res_idx), .res_col(res_col), .res_kind(res_kind)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;
  int unsigned lcg = 1;

  // Scenario table: seed and a hit-density knob (row field range).
  localparam int unsigned SEEDS[8] = '{32'd7, 32'd91, 32'd1234, 32'd55, 32'd8080, 32'd3, 32'd4242, 32'd999};
  localparam int          ROWR[8]  = '{2, 4, 2, 8, 3, 2, 4, 1};

  function automatic int rnd(int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % m);
  endfunction

  task automatic clr();
    for (int i = 0; i < D; i++) begin
      e_v[i] = 0; e_rk[i] = 0; e_rd[i] = 1; e_bk[i] = 0; e_row[i] = 0;
    end
    for (int r = 0; r < RK; r++) rk_ok[r] = 1;
    for (int b = 0; b < NB; b++) begin
      b_open[b] = 0; b_row[b] = 0; b_rd[b] = 0; b_wr[b] = 0; b_act[b] = 0;
    end
    now_t = 0; minc_t = 0; rcd_t = 0;
  endtask

  task automatic add(int i, int rk, int bk, int row, int rd);
    e_v[i] = 1; e_rk[i] = rk[0]; e_bk[i] = bk[1:0]; e_row[i] = row[RW-1:0]; e_rd[i] = rd[0];
  endtask

  // Reference priority function built from R3..R11.
  task automatic ref_pick(output int f, output int idx, output int col, output int kind);
    bit wt[NB], wr_[NB], mk[NB], el[D], ht[D], seamf, hid;
    int hmax, mina, a, c, dv, bid[D], cl[D];
    f = 0; idx = 0; col = 0; kind = 0;
    for (int b = 0; b < NB; b++) begin wt[b] = 0; wr_[b] = 0; mk[b] = 0; end
    for (int i = 0; i < D; i++) begin
      bid[i] = e_rk[i] * BP + e_bk[i];
      el[i] = e_v[i] && rk_ok[e_rk[i]];
      ht[i] = el[i] && b_open[bid[i]] && b_row[bid[i]] == e_row[i];
      cl[i] = e_rd[i] ? b_rd[bid[i]] : b_wr[bid[i]];
      if (el[i]) begin wt[bid[i]] = 1; if (e_rd[i]) wr_[bid[i]] = 1; end
    end
    hmax = (minc_t > rcd_t) ? minc_t - rcd_t : 0;
    if (hmax < now_t) hmax = now_t;
    mina = 32'h7fffffff; seamf = 0; hid = 0;
    for (int b = 0; b < NB; b++) begin
      if (!wt[b]) continue;
      a = (b_act[b] > now_t) ? b_act[b] : now_t;
      dv = wr_[b] ? b_rd[b] : b_wr[b];
      c = (dv > a + rcd_t) ? dv : a + rcd_t;
      if (c <= minc_t || (!seamf && a <= mina)) begin
        if (!seamf && (c <= minc_t || a < mina))
          for (int k = 0; k < NB; k++) mk[k] = 0;
        if (c <= minc_t) seamf = 1;
        mk[b] = 1; hid = (a <= hmax); mina = a;
      end
    end
    for (int i = D - 1; i >= 0; i--) if (ht[i] && cl[i] <= minc_t) begin kind = 1; idx = i; end
    if (kind == 0 && hid)
      for (int i = D - 1; i >= 0; i--) if (el[i] && !ht[i] && mk[bid[i]]) begin kind = 2; idx = i; end
    if (kind == 0)
      for (int i = D - 1; i >= 0; i--) if (ht[i]) begin kind = 3; idx = i; end
    if (kind == 0)
      for (int i = D - 1; i >= 0; i--) if (el[i] && !ht[i] && mk[bid[i]]) begin kind = 4; idx = i; end
    if (kind != 0) begin f = 1; col = cl[idx]; end
  endtask

  task automatic fire();
    @(negedge clk); pick_go = 1'b1;
    @(negedge clk); pick_go = 1'b0;
  endtask

  task automatic chk(string tag, int f, int idx, int col, int kind);
    total++;
    if (int'(res_found) != f || int'(res_idx) != idx || int'(res_col) != col ||
        int'(res_kind) != kind || !res_valid) begin
      fails++;
      $display("FAIL %s: got valid=%0d found=%0d idx=%0d col=%0d kind=%0d exp found=%0d idx=%0d col=%0d kind=%0d",
               tag, res_valid, res_found, res_idx, res_col, res_kind, f, idx, col, kind);
    end
  endtask

  task automatic chk_bit(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  initial begin
    int ef, ei, ec, ek;
    clr();
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (res_valid || res_found || res_idx != 0 || res_col != 0 || res_kind != 0) begin
      fails++;
      $display("FAIL R1: got valid=%0d found=%0d idx=%0d col=%0d kind=%0d exp all 0",
               res_valid, res_found, res_idx, res_col, res_kind);
    end
    rst = 1'b0;
    @(negedge clk);

    // R9: empty queue
    fire(); chk("R9 empty", 0, 0, 0, 0);
    // R2: valid drops the cycle after
    @(negedge clk); chk_bit("R2 valid drop", res_valid, 1'b0);

    // R4: seamless hit, lowest index among seamless
    clr(); minc_t = 20;
    b_open[1] = 1; b_row[1] = 5; b_rd[1] = 10;
    b_open[3] = 1; b_row[3] = 9; b_rd[3] = 30;
    add(0, 0, 2, 7, 1); add(3, 0, 1, 5, 1); add(5, 0, 3, 9, 1); add(6, 0, 1, 5, 1);
    fire(); chk("R4 seamless", 1, 3, 10, 1);

    // R5 / R8: prepped write hit beats non-hidden miss
    clr(); minc_t = 5; rcd_t = 10;
    for (int b = 0; b < NB; b++) b_act[b] = 50;
    b_open[3] = 1; b_row[3] = 9; b_wr[3] = 30;
    add(1, 0, 2, 7, 1); add(4, 0, 3, 9, 0);
    fire(); chk("R5 R8 prepped write hit", 1, 4, 30, 3);

    // R2: results held when no strobe
    minc_t = 40;
    @(negedge clk); @(negedge clk);
    total++;
    if (res_idx != 4 || res_kind != 3) begin
      fails++; $display("FAIL R2 hold: got idx=%0d kind=%0d exp idx=4 kind=3", res_idx, res_kind);
    end

    // R7: hidden miss beats non-seamless hit
    minc_t = 100; b_wr[3] = 150; b_rd[2] = 40;
    fire(); chk("R7 hidden miss", 1, 1, 40, 2);

    // R6 / R11: miss to strictly earliest bank (bank id 5 = rank1 bank1)
    clr(); rcd_t = 10; minc_t = 5;
    b_act[2] = 70; b_act[5] = 20; b_rd[2] = 3; b_rd[5] = 12;
    add(0, 0, 2, 1, 1); add(3, 1, 1, 1, 1);
    fire(); chk("R6 R11 earliest bank miss", 1, 3, 12, 4);

    // R10: now raises both activate times -> tie, hidden by now bound
    now_t = 100;
    fire(); chk("R10 now clamps activate", 1, 0, 3, 2);

    // R3: seamless hit in unavailable rank skipped
    clr(); minc_t = 50;
    b_open[4] = 1; b_row[4] = 2; b_rd[4] = 1;
    b_open[0] = 1; b_row[0] = 3; b_rd[0] = 80;
    add(2, 1, 0, 2, 1); add(7, 0, 0, 3, 1);
    rk_ok[1] = 0;
    fire(); chk("R3 rank unavailable", 1, 7, 80, 3);
    // R3: invalid entries ignored
    e_v[7] = 0;
    fire(); chk("R3 invalid ignored", 0, 0, 0, 0);

    // Table walk, expected from reference priority function (R3..R11)
    for (int s = 0; s < 8; s++) begin
      lcg = SEEDS[s];
      clr();
      for (int i = 0; i < D; i++) begin
        e_v[i] = rnd(4) != 0; e_rk[i] = rnd(2) != 0; e_bk[i] = 2'(rnd(4));
        e_row[i] = RW'(rnd(ROWR[s])); e_rd[i] = rnd(2) != 0;
      end
      for (int r = 0; r < RK; r++) rk_ok[r] = rnd(4) != 0;
      for (int b = 0; b < NB; b++) begin
        b_open[b] = rnd(2) != 0; b_row[b] = RW'(rnd(ROWR[s]));
        b_rd[b] = TW'(rnd(64)); b_wr[b] = TW'(rnd(64)); b_act[b] = TW'(rnd(64));
      end
      now_t = TW'(rnd(40)); minc_t = TW'(rnd(64)); rcd_t = TW'(rnd(16));
      ref_pick(ef, ei, ec, ek);
      fire(); chk($sformatf("R4 R5 R6 R7 R10 table row %0d", s), ef, ei, ec, ek);
    end

    // R1: reset clears a held result
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk_bit("R1 reset clears found", res_found, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule